// File: doc/BRIEF.md
# DMA Remapping Enable Controller

This block owns the on/off switch for the address-remapping stage of a DMA path. Software writes an enable request into a 32-bit command register. The block does not flip the remapping state straight away. It first stalls new DMA transactions. It then waits until every translated request already in flight has completed. Finally it waits until the request stream sits between transactions. Only then does it change the `remap_active` output. A transaction is therefore remapped over its whole length, or not remapped at all.

The outcome of a command shows up in a separate, read-only status register. The enable field of the command register always reads back as zero. The block keeps its own count of outstanding translated requests. A request is counted when its first beat is accepted on the request handshake, and uncounted when the DMA path pulses a completion. While a command is in progress, the register port holds off further command writes through a ready signal. Register offsets are byte addresses: command at 18h, status at 1Ch.

Top module: `remap_enable_ctrl`

## Requirements
- R1: After reset, `remap_active` is 0, the status bit is 0, `reg_wr_ready` is 1, `dma_req_ready` is 1, and `reg_rdata` is 0.
- R2: A write accepted at offset 18h starts a command when its bit 31 differs from the current state (1 = remapping on, 0 = off). `reg_wr_ready` stays low until the command completes. On completion, `remap_active` and status bit 31 at offset 1Ch both take the written value in the same cycle that `reg_wr_ready` returns high.
- R3: The remapping state changes only when the outstanding-request count is zero. A command stays pending for as long as any counted request lacks its completion pulse.
- R4: The remapping state changes only at a transaction boundary, that is, never after a first beat without `dma_req_last` has been accepted and before its last beat is accepted.
- R5: While a command is pending, `dma_req_ready` is 0 whenever no transaction is partly transferred. A transaction that is already partly transferred keeps `dma_req_ready` at 1 until its last beat.
- R6: A write at 18h whose bit 31 equals the current state completes at once. `reg_wr_ready` stays 1 and `remap_active` does not change.
- R7: A read returns data in `reg_rdata` on the cycle after `reg_rd_en`. Offset 18h reads 0. Offset 1Ch reads the status at bit 31 with every other bit 0. Any other offset reads 0.
- R8: Writes to offset 1Ch or to any unmapped offset have no effect on `remap_active`, the status or `reg_wr_ready`.
- R9: The outstanding count never wraps. With 2^CNT_W-1 requests outstanding (15 by default), a new transaction is stalled. A completion pulse with nothing outstanding is ignored.
- R10: Only bit 31 of a command write matters. The other 31 bits are ignored, and each accepted write acts as one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_wr_ready | output | 1 | High when a write can be accepted |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| dma_req_valid | input | 1 | A request beat is offered |
| dma_req_last | input | 1 | The offered beat ends its transaction |
| dma_req_ready | output | 1 | The offered beat is accepted |
| dma_cpl | input | 1 | One translated request has completed |
| remap_active | output | 1 | Remapping is applied to the DMA path |

## Verification
The bench holds an enable command open while requests remain uncompleted. A design that ignored the drain would switch at once, with requests still in flight under the old state. It also keeps a transaction open across a command, by sending a first beat without last and completing the request early, so that a design that switched mid-transaction is caught. A spurious completion with nothing outstanding, followed by a real request, exposes a counter that wraps below zero and so drains too early. Filling the counter to its limit exposes one that overflows. Writes that match the current state, writes to the status offset, and writes with junk in the low bits catch designs that stall, toggle or decode the wrong bit.

// File: rtl/rec_pkg.sv
package rec_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned TE_BIT = 31;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_DRAIN = 2'd1,
        ST_WAIT_BOUND = 2'd2,
        ST_APPLY      = 2'd3
    } rec_state_e;

endpackage

// File: rtl/rec_txn_tracker.sv
// Tracks whether a transaction is partly transferred and how many
// translated requests are still awaiting completion.
module rec_txn_tracker #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    input  logic             beat_last,
    input  logic             beat_ready,
    input  logic             cpl,
    output logic             in_txn,
    output logic [CNT_W-1:0] outstanding,
    output logic             at_max
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             in_txn;
        logic [CNT_W-1:0] cnt;
    } trk_s;

    trk_s trk_d, trk_q;
    logic accept;
    logic start;
    logic inc;
    logic dec;

    always_comb begin
        trk_d  = trk_q;
        accept = beat_valid && beat_ready;
        start  = accept && !trk_q.in_txn;
        inc    = start && (trk_q.cnt != CNT_MAX);
        dec    = cpl && (trk_q.cnt != '0);
        if (accept) begin
            trk_d.in_txn = !beat_last;
        end
        unique case ({inc, dec})
            2'b10:   trk_d.cnt = trk_q.cnt + CNT_ONE;
            2'b01:   trk_d.cnt = trk_q.cnt - CNT_ONE;
            default: trk_d.cnt = trk_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign in_txn      = trk_q.in_txn;
    assign outstanding = trk_q.cnt;
    assign at_max      = (trk_q.cnt == CNT_MAX);

endmodule

// File: rtl/rec_cmd_fsm.sv
// Sequences one enable/disable command: drain, boundary, apply.
module rec_cmd_fsm
    import rec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_te,
    input  logic drained,
    input  logic in_txn,
    output logic idle,
    output logic remap
);

    typedef struct packed {
        rec_state_e state;
        logic       target;
        logic       remap;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_IDLE: begin
                // a request equal to the present state is simply re-confirmed
                if (cmd_valid && (cmd_te != fsm_q.remap)) begin
                    fsm_d.target = cmd_te;
                    fsm_d.state  = ST_WAIT_DRAIN;
                end
            end
            ST_WAIT_DRAIN: begin
                if (drained) begin
                    fsm_d.state = ST_WAIT_BOUND;
                end
            end
            ST_WAIT_BOUND: begin
                if (!in_txn) begin
                    fsm_d.state = ST_APPLY;
                end
            end
            ST_APPLY: begin
                fsm_d.remap = fsm_q.target;
                fsm_d.state = ST_IDLE;
            end
            default: fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_IDLE, target: 1'b0, remap: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign idle  = (fsm_q.state == ST_IDLE);
    assign remap = fsm_q.remap;

endmodule

// File: rtl/rec_reg_port.sv
// Decodes the command and status offsets; registered read data.
module rec_reg_port
    import rec_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CMD_OFS  = 'h18,
    parameter int unsigned STAT_OFS = 'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ready,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wdata_te,
    input  logic              status,
    output logic              cmd_valid,
    output logic              cmd_te,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rp_s;

    rp_s rp_d, rp_q;

    always_comb begin
        rp_d      = rp_q;
        cmd_valid = wr_en && wr_ready && (addr == CMD_A);
        cmd_te    = wdata_te;
        if (rd_en) begin
            rp_d.rdata = '0;
            if (addr == STAT_A) begin
                rp_d.rdata[TE_BIT] = status;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign rdata = rp_q.rdata;

endmodule

// File: rtl/remap_enable_ctrl.sv
module remap_enable_ctrl
    import rec_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned CMD_OFS  = 'h18,
    parameter int unsigned STAT_OFS = 'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              reg_wr_ready,
    output logic [31:0]       reg_rdata,
    input  logic              dma_req_valid,
    input  logic              dma_req_last,
    output logic              dma_req_ready,
    input  logic              dma_cpl,
    output logic              remap_active
);

    logic             in_txn;
    logic [CNT_W-1:0] outstanding;
    logic             at_max;
    logic             cmd_idle;
    logic             remap;
    logic             cmd_valid;
    logic             cmd_te;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[TE_BIT-1:0];

    // a started transaction always runs to its last beat; a new one
    // starts only while no command is pending and the count has room
    assign dma_req_ready = in_txn || (cmd_idle && !at_max);
    assign reg_wr_ready  = cmd_idle;
    assign remap_active  = remap;

    rec_txn_tracker #(
        .CNT_W(CNT_W)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (dma_req_valid),
        .beat_last  (dma_req_last),
        .beat_ready (dma_req_ready),
        .cpl        (dma_cpl),
        .in_txn     (in_txn),
        .outstanding(outstanding),
        .at_max     (at_max)
    );

    rec_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_te   (cmd_te),
        .drained  (outstanding == '0),
        .in_txn   (in_txn),
        .idle     (cmd_idle),
        .remap    (remap)
    );

    rec_reg_port #(
        .ADDR_W  (ADDR_W),
        .CMD_OFS (CMD_OFS),
        .STAT_OFS(STAT_OFS)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_ready (cmd_idle),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata_te (reg_wdata[TE_BIT]),
        .status   (remap),
        .cmd_valid(cmd_valid),
        .cmd_te   (cmd_te),
        .rdata    (reg_rdata)
    );

endmodule

// File: rtl/remap_enable_ctrl_chk.sv
module remap_enable_ctrl_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned CMD_OFS  = 'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              reg_wr_ready,
    input logic              dma_req_ready,
    input logic              dma_req_valid,
    input logic              dma_cpl,
    input logic              remap_active,
    input logic              in_txn,
    input logic [CNT_W-1:0]  outstanding
);

    localparam logic [ADDR_W-1:0] CMD_A   = ADDR_W'(CMD_OFS);
    localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};

    // R2: the state changes exactly when the port becomes ready again
    a_r2_apply_frees_port: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(remap_active) |-> reg_wr_ready);

    // R3
    a_r3_switch_drained: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(remap_active) |-> $past(outstanding) == '0);

    // R4
    a_r4_switch_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(remap_active) |-> !$past(in_txn));

    // R5
    a_r5_stall_new: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_ready && !in_txn) |-> !dma_req_ready);

    a_r5_finish_open: assert property (@(posedge clk) disable iff (!rst_n)
        in_txn |-> dma_req_ready);

    // R6
    a_r6_match_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_ready && reg_addr == CMD_A && reg_wdata[31] == remap_active)
        |=> (reg_wr_ready && $stable(remap_active)));

    // R8
    a_r8_other_ofs_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_ready && reg_addr != CMD_A) |=> (reg_wr_ready && $stable(remap_active)));

    // R9
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding == CNT_MAX && !in_txn) |-> !dma_req_ready);

    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding == '0 && dma_cpl && !(dma_req_valid && dma_req_ready && !in_txn))
        |=> outstanding == '0);

endmodule

bind remap_enable_ctrl remap_enable_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .CMD_OFS(CMD_OFS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_wr_ready (reg_wr_ready),
    .dma_req_ready(dma_req_ready),
    .dma_req_valid(dma_req_valid),
    .dma_cpl      (dma_cpl),
    .remap_active (remap_active),
    .in_txn       (in_txn),
    .outstanding  (outstanding)
);

// File: tb/remap_enable_ctrl_test.sv
`timescale 1ns/1ps
module remap_enable_ctrl_test;

    localparam int ADDR_W = 8;
    localparam int CNT_W  = 4;
    localparam int MAXO   = (1 << CNT_W) - 1;
    localparam logic [7:0] A_CMD  = 8'h18;
    localparam logic [7:0] A_STAT = 8'h1C;
    localparam logic [7:0] A_NONE = 8'h44;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic reg_wr_ready;
    logic [31:0] reg_rdata;
    logic dma_req_valid = 1'b0, dma_req_last = 1'b0, dma_cpl = 1'b0;
    logic dma_req_ready;
    logic remap_active;

    always #2 clk = ~clk;

    remap_enable_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr_ready(reg_wr_ready), .reg_rdata(reg_rdata),
        .dma_req_valid(dma_req_valid), .dma_req_last(dma_req_last),
        .dma_req_ready(dma_req_ready), .dma_cpl(dma_cpl), .remap_active(remap_active)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    int m_out = 0;
    bit m_in_txn = 1'b0;
    bit pend = 1'b0, pend_te = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit is_cmd_change(bit we, bit acc, logic [7:0] a, bit te, bit cur);
        return we && acc && (a == A_CMD) && (te != cur);
    endfunction

    // one cycle: drive at a falling edge, commit at the rising edge,
    // return at the next falling edge with the reference model updated
    task automatic step(input bit v, input bit l, input bit c, input bit we, input bit re,
                        input logic [7:0] a, input logic [31:0] wd);
        bit rdy, wrdy, acc, prev_remap, prev_in, start;
        int prev_out;
        dma_req_valid = v; dma_req_last = l; dma_cpl = c;
        reg_wr_en = we; reg_rd_en = re; reg_addr = a; reg_wdata = wd;
        #1;
        rdy = dma_req_ready; wrdy = reg_wr_ready; prev_remap = remap_active;
        prev_in = m_in_txn; prev_out = m_out;
        acc = v && rdy;
        start = acc && !m_in_txn;
        if (is_cmd_change(we, wrdy, a, wd[31], prev_remap)) begin
            pend = 1'b1; pend_te = wd[31];
        end
        @(posedge clk);
        if (acc) m_in_txn = !l;
        if (start) m_out++;
        if (c && prev_out > 0) m_out--;
        @(negedge clk);
        dma_req_valid = 0; dma_req_last = 0; dma_cpl = 0; reg_wr_en = 0; reg_rd_en = 0;
        if (remap_active != prev_remap) begin
            check(prev_out == 0, "R3 switch with requests outstanding", prev_out, 0);
            check(!prev_in, "R4 switch inside a transaction", prev_in, 0);
        end
        if (pend && reg_wr_ready) begin
            check(remap_active == pend_te, "R2 state after command", remap_active, pend_te);
            pend = 1'b0;
        end
        if (!reg_wr_ready && !m_in_txn)
            check(dma_req_ready == 1'b0, "R5 new transaction not stalled", dma_req_ready, 0);
        if (m_in_txn)
            check(dma_req_ready == 1'b1, "R5 open transaction stalled", dma_req_ready, 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 8'h0, 32'h0);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        step(0, 0, 0, 0, 1, a, 32'h0);
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(0, 0, 0, 1, 0, a, d);
    endtask

    task automatic settle();
        for (int i = 0; i < 40 && pend; i++) idle(1);
        check(!pend, "R2 command never completed", pend, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd777));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        check(remap_active == 0, "R1 remap_active", remap_active, 0);
        check(reg_wr_ready == 1, "R1 reg_wr_ready", reg_wr_ready, 1);
        check(dma_req_ready == 1, "R1 dma_req_ready", dma_req_ready, 1);
        check(reg_rdata == 0, "R1 reg_rdata", reg_rdata, 0);
        // R7
        rd(A_STAT, 32'h0, "R7 status after reset");
        rd(A_CMD, 32'h0, "R7 command reads zero");
        rd(A_NONE, 32'h0, "R7 unmapped reads zero");
        // R8
        wr(A_STAT, 32'h8000_0000);
        check(reg_wr_ready == 1 && remap_active == 0, "R8 status write", {reg_wr_ready, remap_active}, 2'b10);
        wr(A_NONE, 32'hFFFF_FFFF);
        check(reg_wr_ready == 1 && remap_active == 0, "R8 unmapped write", {reg_wr_ready, remap_active}, 2'b10);
        // R6 / R10: bit 31 equals state, junk elsewhere
        wr(A_CMD, 32'h7FFF_FFFF);
        check(reg_wr_ready == 1 && remap_active == 0, "R6 matching write", {reg_wr_ready, remap_active}, 2'b10);
        // R3: drain two requests
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        wr(A_CMD, 32'h8000_0000);
        idle(8);
        check(remap_active == 0 && reg_wr_ready == 0, "R3 held while draining", {reg_wr_ready, remap_active}, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        idle(5);
        check(remap_active == 0, "R3 held with one outstanding", remap_active, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        settle();
        check(remap_active == 1, "R2 enabled", remap_active, 1);
        rd(A_STAT, 32'h8000_0000, "R7 status enabled");
        rd(A_CMD, 32'h0, "R7 command enable reads zero");
        // R6 while enabled
        wr(A_CMD, 32'hFFFF_FFFF);
        check(reg_wr_ready == 1 && remap_active == 1, "R6 matching enable", {reg_wr_ready, remap_active}, 2'b11);
        // R4: open transaction, its request completed early
        step(1, 0, 0, 0, 0, 0, 0);
        wr(A_CMD, 32'h0);
        step(0, 0, 1, 0, 0, 0, 0);
        idle(6);
        check(remap_active == 1, "R4 held inside transaction", remap_active, 1);
        check(dma_req_ready == 1, "R5 open transaction may finish", dma_req_ready, 1);
        step(1, 1, 0, 0, 0, 0, 0);
        settle();
        check(remap_active == 0, "R4 disabled after boundary", remap_active, 0);
        // R9 underflow
        step(0, 0, 1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        wr(A_CMD, 32'h8000_0000);
        idle(6);
        check(remap_active == 0, "R9 spurious completion ignored", remap_active, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        settle();
        // R9 overflow
        for (int i = 0; i < MAXO; i++) step(1, 1, 0, 0, 0, 0, 0);
        check(m_out == MAXO, "R9 requests accepted to limit", m_out, MAXO);
        check(dma_req_ready == 0, "R9 stall at limit", dma_req_ready, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        check(dma_req_ready == 1, "R9 room after completion", dma_req_ready, 1);
        for (int i = 0; i < MAXO - 1; i++) step(0, 0, 1, 0, 0, 0, 0);
        // R10: bit 31 clear with junk below it disables
        wr(A_CMD, 32'h7FFF_FFFE);
        settle();
        check(remap_active == 0, "R10 only bit 31 decoded", remap_active, 0);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit v, l, c, we;
            logic [7:0] a;
            logic [31:0] d;
            v = ($urandom % 2) == 0;
            l = ($urandom % 3) == 0;
            c = (m_out > 0) && (($urandom % 4) == 0);
            we = ($urandom % 30) == 0;
            a = (($urandom % 4) == 0) ? A_STAT : A_CMD;
            d = $urandom;
            step(v, l, c, we, 0, a, d);
        end
        if (m_in_txn) step(1, 1, 0, 0, 0, 0, 0);
        while (m_out > 0) step(0, 0, 1, 0, 0, 0, 0);
        settle();
        rd(A_STAT, {remap_active, 31'h0}, "R7 final status");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule